// File: doc/BRIEF.md
# Serial Register Port with Indirect Memory Window

This block is a serial slave that hangs a small register file and a 256-byte memory off a four-wire synchronous serial link (chip select, serial clock, data in, data out). The memory cannot be reached directly. The host first loads an 8-bit memory pointer register. It then moves bytes through a single data-port register, and the memory pointer advances by one after each byte. One transfer can therefore stream any number of bytes, and the pointer wraps from the top of the array back to zero. A control register carries one flag bit, which drives a pin into the rest of the chip.

A transfer begins when chip select goes low and ends when it goes high. The first byte is a header: its top bit marks a write and its lower seven bits name the register. Every later byte in the transfer is a data byte. All serial pins are brought into the system clock domain through two-flop synchronizers, so the serial clock must run well below the system clock. The data-out line stays high-impedance except while a read byte is being shifted out.

Top module: `spi_win_top`

## Requirements
- R1: After reset the flag output is 0, the data-out enable is low and the data-out line is high-impedance.
- R2: Bits travel most significant first, one serial clock per bit, eight bits per byte. Input is sampled on the rising serial clock edge and output changes on the falling edge. Transfers work whether the clock idles low or idles high. Header bit 7 = 1 means write and bits 6..0 give the register index.
- R3: Register 13h is the control register. Writing it sets the flag output to bit 0 of the data byte. Reading it returns 0000000 followed by the flag.
- R4: Register 18h holds the memory pointer. A write loads the pointer and a read returns its value.
- R5: Register 19h is the data port. A read returns the memory byte at the pointer and a write stores the byte there. Each data-port byte that is fully clocked advances the memory pointer by one, and the register index stays at 19h for the rest of the transfer.
- R6: The memory pointer wraps from FFh to 00h.
- R7: After each data byte to or from any register other than 19h, the register index goes up by one within the transfer.
- R8: The data-out enable is low throughout the header byte and throughout a write transfer. In a read transfer it goes high at the first falling edge after the header, once a full byte is ready. It goes low again when chip select is released.
- R9: If chip select is released partway through a byte, that byte is discarded. Nothing is written and the memory pointer does not move.
- R10: Register indices other than 13h, 18h and 19h read as 00h, and writes to them change nothing.
- R11: A byte fetched ahead for a read but never clocked out in full does not advance the memory pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low; frames one transfer |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host; high-impedance when not enabled |
| spi_miso_oe | output | 1 | High while spi_miso is driven |
| conv_dis | output | 1 | Flag bit 0 of the control register |

## Verification
A wrong register index or a wrong memory pointer appears at the ports as a wrong data byte. It shows in the very next read of the data port or of the pointer register, and wrap and prefetch errors show up as an off-by-one pointer value. An output-enable fault shows within one bit time as a driven line during a header or a write, or as a high-impedance bit inside a read byte. A partial byte that leaks through shows up as changed memory contents or a moved pointer in the transfer that follows.

// File: rtl/spi_win_pkg.sv
package spi_win_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {PH_HDR, PH_WR, PH_RD} phase_t;
endpackage

// File: rtl/spi_win_sync.sv
module spi_win_sync #(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= {2{RST_VAL[i]}};
        else        st <= {st[0], d[i]};
      end
      assign q[i] = st[1];
    end
  endgenerate
endmodule

// File: rtl/spi_win_serdes.sv
module spi_win_serdes #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso_d,
  output logic              miso_oe
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic              armed;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      armed     <= 1'b0;
      byte_done <= 1'b0;
      miso_d    <= 1'b0;
      miso_oe   <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt   <= '0;
      armed     <= 1'b0;
      byte_done <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        rx_sr <= {rx_sr[BYTE_W-2:0], mosi_s};
        if (bit_cnt == CNT_W'(BYTE_W-1)) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (tx_load) begin
        tx_sr <= tx_byte;
        armed <= 1'b1;
      end else if (fall) begin
        miso_d <= tx_sr[BYTE_W-1];
        tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
        if (armed) miso_oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_win_regs.sv
module spi_win_regs
  import spi_win_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DW       = 8,
  parameter logic [DW-2:0]     CTRL_IDX = 7'h13,
  parameter logic [DW-2:0]     PTR_IDX  = 7'h18,
  parameter logic [DW-2:0]     DATA_IDX = 7'h19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_load,
  output logic [DW-1:0] tx_byte,
  output logic          conv_dis,
  output phase_t        phase
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int IDX_W = DW - 1;

  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] mem_ptr;
  logic [IDX_W-1:0]  reg_ptr;
  logic              is_data, is_ptr, is_ctrl;
  logic              got, wr_byte, adv;

  assign is_data = (reg_ptr == DATA_IDX);
  assign is_ptr  = (reg_ptr == PTR_IDX);
  assign is_ctrl = (reg_ptr == CTRL_IDX);
  assign got     = cs_act && byte_done;
  assign wr_byte = got && (phase == PH_WR);
  assign adv     = got && (phase != PH_HDR);

  always_comb begin
    tx_byte = '0;
    if (is_data)      tx_byte = mem[mem_ptr];
    else if (is_ptr)  tx_byte = DW'(mem_ptr);
    else if (is_ctrl) tx_byte = {{(DW-1){1'b0}}, conv_dis};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HDR;
      reg_ptr  <= '0;
      conv_dis <= 1'b0;
      tx_load  <= 1'b0;
    end else if (!cs_act) begin
      phase   <= PH_HDR;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (got && phase == PH_HDR) begin
        reg_ptr <= rx_byte[IDX_W-1:0];
        if (rx_byte[DW-1]) phase <= PH_WR;
        else begin
          phase   <= PH_RD;
          tx_load <= 1'b1;
        end
      end else if (adv) begin
        if (wr_byte && is_ctrl) conv_dis <= rx_byte[0];
        if (!is_data) reg_ptr <= reg_ptr + 1'b1;
        if (phase == PH_RD) tx_load <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte && is_data) mem[mem_ptr] <= rx_byte;
    if (wr_byte && is_ptr)  mem_ptr <= rx_byte[ADDR_W-1:0];
    else if (adv && is_data) mem_ptr <= mem_ptr + 1'b1;
  end
endmodule

// File: rtl/spi_win_top.sv
module spi_win_top
  import spi_win_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sclk,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic conv_dis
);
  logic [2:0]        pins_s;
  logic              cs_act;
  logic              byte_done, tx_load, miso_d;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  phase_t            phase;

  spi_win_sync #(.WIDTH(3), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sclk, spi_mosi}), .q(pins_s)
  );

  assign cs_act = ~pins_s[2];

  spi_win_serdes #(.BYTE_W(BYTE_W)) serdes_i (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .miso_d(miso_d), .miso_oe(spi_miso_oe)
  );

  spi_win_regs #(.ADDR_W(ADDR_W), .DW(BYTE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .conv_dis(conv_dis), .phase(phase)
  );

  assign spi_miso = spi_miso_oe ? miso_d : 1'bz;
endmodule

// File: rtl/spi_win_chk.sv
module spi_win_chk
  import spi_win_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cs_act,
  input logic   byte_done,
  input logic   tx_load,
  input logic   miso_oe,
  input logic   conv_dis,
  input phase_t phase
);
  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe);

  // R8
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WR) |-> !miso_oe);

  // R5
  load_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (phase == PH_RD));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(conv_dis));
endmodule

bind spi_win_top spi_win_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
  .tx_load(tx_load), .miso_oe(spi_miso_oe), .conv_dis(conv_dis),
  .phase(phase)
);

// File: tb/spi_win_top_tb_top.sv
module spi_win_top_tb_top;
  localparam int HALF = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sclk, mosi;
  wire  miso;
  logic miso_oe, conv_dis;

  spi_win_top dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .conv_dis(conv_dis)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] mo [0:299];
  logic [7:0] mi [0:299];
  logic       oe_lo [0:299];
  logic       oe_hi [0:299];
  logic [7:0] emem [0:255];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(int cpol, int nbits);
    sclk = cpol[0];
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      int b = i / 8;
      int k = 7 - (i % 8);
      if (i % 8 == 0) begin
        mi[b] = '0; oe_lo[b] = 1'b0; oe_hi[b] = 1'b0;
      end
      if (cpol != 0) sclk = 1'b0;
      mosi = mo[b][k];
      wait_clk(HALF);
      mi[b][k] = (miso === 1'b1);
      if (miso_oe) oe_hi[b] = 1'b1; else oe_lo[b] = 1'b1;
      sclk = 1'b1;
      wait_clk(HALF);
      if (cpol == 0) sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic set_ptr(int cpol, logic [7:0] p);
    mo[0] = 8'h98; mo[1] = p;
    xfer(cpol, 16);
  endtask

  task automatic read_ptr(int cpol, logic [7:0] exp, string req);
    mo[0] = 8'h18; mo[1] = 8'h00;
    xfer(cpol, 16);
    check(req, mi[1], exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check("R1 flag", conv_dis, 0);
    check("R1 oe", miso_oe, 0);
    check("R1 hiz", (miso === 1'bz), 1);

    // R3 control register, both clock idle levels
    mo[0] = 8'h93; mo[1] = 8'hFF; xfer(0, 16);
    check("R3 flag set", conv_dis, 1);
    mo[0] = 8'h13; mo[1] = 8'h00; xfer(1, 16);
    check("R3 read one", mi[1], 8'h01);
    mo[0] = 8'h93; mo[1] = 8'hFE; xfer(1, 16);
    check("R3 flag clr", conv_dis, 0);
    mo[0] = 8'h13; xfer(0, 16);
    check("R3 read zero", mi[1], 8'h00);

    // R5 R6 R7 R8: full burst write from 80h, pointer written in same frame
    mo[0] = 8'h98; mo[1] = 8'h80;
    for (int k = 0; k < 256; k++) begin
      mo[2 + k] = pat((8'h80 + k) & 255);
      emem[(8'h80 + k) & 255] = mo[2 + k];
    end
    xfer(0, 258 * 8);
    begin
      logic any_hi = 1'b0;
      for (int b = 0; b < 258; b++) any_hi |= oe_hi[b];
      check("R8 write oe low", any_hi, 0);
    end

    // R4 R6 R7: pointer wrapped back to 80h; index then steps to data port
    mo[0] = 8'h18; mo[1] = 8'h00; mo[2] = 8'h00; xfer(1, 24);
    check("R6 wrap ptr", mi[1], 8'h80);
    check("R7 step to data", mi[2], emem[8'h80]);
    read_ptr(0, 8'h81, "R5 one advance");

    // R5 R6 R8 R11: long read burst wrapping past FFh, idle-high clock
    set_ptr(0, 8'h80);
    mo[0] = 8'h19;
    for (int k = 1; k < 260; k++) mo[k] = 8'h00;
    xfer(1, 259 * 8);
    check("R8 header oe low", oe_hi[0], 0);
    begin
      logic gap = 1'b0;
      for (int k = 0; k < 258; k++) begin
        check("R5 burst read", mi[1 + k], emem[(8'h80 + k) & 255]);
        gap |= oe_lo[1 + k];
      end
      check("R8 read oe high", gap, 0);
    end
    check("R8 released", miso_oe, 0);
    read_ptr(0, 8'h82, "R11 no prefetch advance");

    // R4 R6 R11: pointer sweep near edges
    foreach (mo[i]) if (i < 4) mo[i] = mo[i];
    for (int s = 0; s < 4; s++) begin
      int st = (s == 0) ? 0 : (s == 1) ? 8'h7F : (s == 2) ? 8'hFE : 8'hFF;
      for (int n = 1; n <= 3; n += 2) begin
        set_ptr(s % 2, 8'(st));
        read_ptr(s % 2, 8'(st), "R4 ptr readback");
        set_ptr(s % 2, 8'(st));
        mo[0] = 8'h19; mo[1] = 8'h00; mo[2] = 8'h00; mo[3] = 8'h00;
        xfer((s + n) % 2, (n + 1) * 8);
        for (int k = 0; k < n; k++)
          check("R5 sweep data", mi[1 + k], emem[(st + k) & 255]);
        read_ptr(0, 8'((st + n) & 255), "R6 sweep ptr");
      end
    end

    // R5 R6: write burst across the top, idle-high clock
    mo[0] = 8'h98; mo[1] = 8'hFD;
    for (int k = 0; k < 4; k++) begin
      mo[2 + k] = 8'hC0 + 8'(k);
      emem[(8'hFD + k) & 255] = mo[2 + k];
    end
    xfer(1, 6 * 8);
    set_ptr(0, 8'hFD);
    mo[0] = 8'h19; xfer(0, 5 * 8);
    for (int k = 0; k < 4; k++)
      check("R6 wrap write", mi[1 + k], emem[(8'hFD + k) & 255]);

    // R9: abort mid-byte on write and on read
    set_ptr(0, 8'h40);
    mo[0] = 8'h99; mo[1] = 8'h5A; xfer(0, 13);
    read_ptr(1, 8'h40, "R9 ptr after write abort");
    set_ptr(1, 8'h40);
    mo[0] = 8'h19; mo[1] = 8'h00; xfer(0, 16);
    check("R9 data kept", mi[1], emem[8'h40]);
    mo[0] = 8'h19; xfer(1, 11);
    check("R9 oe after abort", miso_oe, 0);
    read_ptr(0, 8'h41, "R9 ptr after read abort");

    // R10: unmapped index
    mo[0] = 8'h85; mo[1] = 8'hAA; mo[2] = 8'hBB; xfer(0, 24);
    mo[0] = 8'h05; mo[1] = 8'h00; mo[2] = 8'h00; xfer(1, 24);
    check("R10 read zero a", mi[1], 8'h00);
    check("R10 read zero b", mi[2], 8'h00);
    check("R10 flag kept", conv_dis, 0);
    read_ptr(0, 8'h41, "R10 ptr kept");

    // R7: index steps from 12h into control register
    mo[0] = 8'h92; mo[1] = 8'h55; mo[2] = 8'h01; xfer(1, 24);
    check("R7 step write", conv_dis, 1);
    mo[0] = 8'h12; mo[1] = 8'h00; mo[2] = 8'h00; xfer(0, 24);
    check("R7 step read", mi[2], 8'h01);
    check("R2 header byte count", mi[1], 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule